// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external SPI master (clock idle low, data captured on the rising clock edge) read and write a 64-entry byte register space through a plain parallel register port. All three SPI inputs are brought into the system clock domain through two-flop synchronisers. The system clock must run several times faster than SCLK, so every SCLK edge shows up as a one-cycle event.

A frame opens when chip select goes low. Its first byte is a command. The command gives the transfer direction, an auto-increment flag and a six-bit register index. Each later byte is either written into the register file or read from it. On a write, the block issues a one-cycle write strobe with address and data. On a read, it fetches the byte from the register port as soon as the command or the previous data byte completes, and shifts it out on MISO.

Indices 0x3A to 0x3F do not exist. An access to one of them raises an error pulse, writes nothing and reads back zero. Raising chip select at any point ends the frame and throws away any unfinished byte.

Top module: `spi_regbus_slave`

## Requirements
- R1: While the synchronised chip select is high, `miso_oe` is 0 and `miso` is 0. A few system clocks after chip select goes low, `miso_oe` becomes 1.
- R2: The first byte after chip select falls is the command, taken from MOSI MSB first on rising SCLK edges. Its first bit selects the direction (1 = read, 0 = write), its second bit is the auto-increment flag, and its last six bits are the register index, MSB first.
- R3: In a write frame, every complete data byte (MSB first) to a valid index produces exactly one single-cycle `reg_we`, with `reg_addr` set to the index and `reg_wdata` set to the byte.
- R4: In a read frame, the byte at the current index is shifted out on `miso` MSB first. The first bit is already valid before the first rising SCLK edge of the data byte, and each following bit changes after a falling SCLK edge.
- R5: With the auto-increment flag set, the index advances by one (modulo 64) after every data byte. With the flag clear, every data byte uses the command's index.
- R6: Indices 0x3A to 0x3F are invalid. A data byte aimed at one gives no `reg_we` and a single-cycle `addr_err`, and a read of one returns 0x00. Valid indices 0x00 to 0x39 never raise `addr_err`.
- R7: Chip select rising in the middle of a byte ends the frame with no write for that partial byte. The next chip select fall starts again with a command byte.
- R8: During and right after reset, `reg_we`, `addr_err`, `miso` and `miso_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock from the master, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Drive enable for the MISO pad |
| reg_addr | output | 6 | Register index toward the register file |
| reg_wdata | output | 8 | Write data toward the register file |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Read data from the register file at `reg_addr` |
| addr_err | output | 1 | Single-cycle pulse for a data byte aimed at an invalid index |

## Verification
The bench runs frames whose auto-increment walks from 0x38 across the valid limit. A design with an off-by-one range check would either write 0x3A or fail to write 0x39. It also runs write frames with auto-increment off. A design that advanced the index anyway would disturb the neighbouring register, and the bench checks the whole register file after every frame to catch that. Read frames check the first MISO bit of each byte. A design that shifted on the falling edge right after the command would return every byte rotated by one bit. A frame cut off four bits into a byte catches a design that commits partial data, and the command-byte read that follows catches one that fails to restart cleanly.

// File: rtl/spi_regbus_pkg.sv
package spi_regbus_pkg;

    parameter int unsigned RB_ADDR_W = 6;
    parameter int unsigned RB_DATA_W = 8;
    localparam int unsigned RB_CNT_W = $clog2(RB_DATA_W);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e                 phase;
        logic [RB_CNT_W-1:0]    bit_cnt;
        logic [RB_DATA_W-2:0]   rx_sh;
        logic [RB_DATA_W-1:0]   tx_sh;
        logic                   rd;
        logic                   mb;
        logic [RB_ADDR_W-1:0]   addr;
        logic                   post;
        logic                   adv;
        logic                   load;
        logic                   we;
        logic [RB_DATA_W-1:0]   wdata;
        logic [RB_ADDR_W-1:0]   waddr;
        logic                   err;
        logic                   oe;
        logic                   sclk_prev;
        logic                   cs_prev;
    } rb_state_t;

endpackage

// File: rtl/spi_sync_bits.sv
module spi_sync_bits #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= {chain_q[STAGES-2:0], d[b]};
        end
        assign q[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/spi_addr_check.sv
module spi_addr_check #(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned MAX_ADDR = 57
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              valid
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(MAX_ADDR);
    assign valid = (addr <= LIMIT);
endmodule

// File: rtl/spi_regbus_slave.sv
module spi_regbus_slave
    import spi_regbus_pkg::*;
#(
    parameter int unsigned ADDR_W      = RB_ADDR_W,
    parameter int unsigned DATA_W      = RB_DATA_W,
    parameter int unsigned MAX_ADDR    = 57,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              addr_err
);
    localparam int unsigned CNT_W = RB_CNT_W;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [2:0] sync_q;
    logic       cs_lvl, sclk_lvl, mosi_lvl;
    logic       sclk_rise, sclk_fall, cs_fall;
    logic       addr_ok;
    logic [DATA_W-1:0] byte_v;
    rb_state_t  s_d, s_q;

    spi_sync_bits #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs_n, sclk, mosi}),
        .q    (sync_q)
    );

    assign cs_lvl   = sync_q[2];
    assign sclk_lvl = sync_q[1];
    assign mosi_lvl = sync_q[0];

    assign sclk_rise = sclk_lvl & ~s_q.sclk_prev;
    assign sclk_fall = ~sclk_lvl & s_q.sclk_prev;
    assign cs_fall   = ~cs_lvl & s_q.cs_prev;

    spi_addr_check #(
        .ADDR_W  (ADDR_W),
        .MAX_ADDR(MAX_ADDR)
    ) chk_addr_i (
        .addr (s_q.addr),
        .valid(addr_ok)
    );

    always_comb begin
        s_d           = s_q;
        s_d.we        = 1'b0;
        s_d.err       = 1'b0;
        s_d.load      = 1'b0;
        s_d.post      = 1'b0;
        s_d.sclk_prev = sclk_lvl;
        s_d.cs_prev   = cs_lvl;
        byte_v        = {s_q.rx_sh, mosi_lvl};

        if (cs_lvl) begin
            s_d.phase   = PH_IDLE;
            s_d.bit_cnt = '0;
            s_d.tx_sh   = '0;
            s_d.oe      = 1'b0;
            s_d.adv     = 1'b0;
        end else begin
            s_d.oe = 1'b1;
            if (cs_fall) begin
                s_d.phase   = PH_CMD;
                s_d.bit_cnt = '0;
                s_d.tx_sh   = '0;
                s_d.rd      = 1'b0;
                s_d.mb      = 1'b0;
                s_d.adv     = 1'b0;
            end else begin
                // step after a byte: advance index, then fetch read data
                if (s_q.post) begin
                    if (s_q.adv) s_d.addr = s_q.addr + 1'b1;
                    if (s_q.rd)  s_d.load = 1'b1;
                end
                if (s_q.load) begin
                    s_d.tx_sh = addr_ok ? reg_rdata : '0;
                end
                if (sclk_fall && s_q.phase == PH_DATA && s_q.bit_cnt != '0) begin
                    s_d.tx_sh = {s_q.tx_sh[DATA_W-2:0], 1'b0};
                end
                if (sclk_rise && s_q.phase != PH_IDLE) begin
                    s_d.bit_cnt = s_q.bit_cnt + 1'b1;
                    s_d.rx_sh   = byte_v[DATA_W-2:0];
                    if (s_q.bit_cnt == LAST_BIT) begin
                        s_d.post = 1'b1;
                        if (s_q.phase == PH_CMD) begin
                            s_d.rd    = byte_v[DATA_W-1];
                            s_d.mb    = byte_v[DATA_W-2];
                            s_d.addr  = byte_v[ADDR_W-1:0];
                            s_d.adv   = 1'b0;
                            s_d.phase = PH_DATA;
                        end else begin
                            s_d.adv = s_q.mb;
                            if (!addr_ok) begin
                                s_d.err = 1'b1;
                            end else if (!s_q.rd) begin
                                s_d.we    = 1'b1;
                                s_d.wdata = byte_v;
                                s_d.waddr = s_q.addr;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.phase     <= PH_IDLE;
            s_q.cs_prev   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign miso      = s_q.tx_sh[DATA_W-1];
    assign miso_oe   = s_q.oe;
    assign reg_we    = s_q.we;
    assign reg_wdata = s_q.wdata;
    assign reg_addr  = s_q.we ? s_q.waddr : s_q.addr;
    assign addr_err  = s_q.err;

endmodule

// File: rtl/spi_regbus_slave_chk.sv
module spi_regbus_slave_chk #(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned MAX_ADDR = 57
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miso,
    input logic              miso_oe,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              addr_err
);
    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !miso_oe |-> !miso); // R1
    AST_WE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) reg_we |-> miso_oe); // R7
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) reg_we |=> !reg_we); // R3
    AST_WE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) reg_we |-> (reg_addr <= ADDR_W'(MAX_ADDR))); // R6
    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({reg_we, addr_err})); // R6
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) addr_err |=> !addr_err); // R6
endmodule

bind spi_regbus_slave spi_regbus_slave_chk #(
    .ADDR_W  (ADDR_W),
    .MAX_ADDR(MAX_ADDR)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .miso    (miso),
    .miso_oe (miso_oe),
    .reg_we  (reg_we),
    .reg_addr(reg_addr),
    .addr_err(addr_err)
);

// File: tb/spi_regbus_slave_tb_top.sv
`timescale 1ns/1ps
module spi_regbus_slave_tb_top;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso, miso_oe, reg_we, addr_err;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    always #2.5 clk = ~clk;

    spi_regbus_slave dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
        .addr_err(addr_err)
    );

    logic [7:0] mem [64];
    logic [7:0] exp_mem [64];
    int we_cnt = 0;
    int err_cnt = 0;
    int n_run = 0;
    int n_fail = 0;
    logic [7:0] tx_buf [4];
    logic [7:0] rx_buf [4];

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
    end

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (addr_err) err_cnt <= err_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // nbytes: bytes including command; last byte sends only last_bits bits
    task automatic xfer(input int nbytes, input int last_bits);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < nbytes; b++) begin
            int nb;
            nb = (b == nbytes - 1) ? last_bits : 8;
            rx_buf[b] = 8'h00;
            for (int i = 7; i > 7 - nb; i--) begin
                mosi = tx_buf[b][i];
                repeat (HALF) @(negedge clk);
                rx_buf[b][i] = miso;
                sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                sclk = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    typedef struct packed {
        logic       rd;
        logic       mb;
        logic [5:0] addr;
        logic [1:0] nb;
        logic [7:0] d0;
        logic [7:0] d1;
        logic [7:0] d2;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b0, 1'b0, 6'h05, 2'd1, 8'hA5, 8'h00, 8'h00},
        '{1'b1, 1'b0, 6'h05, 2'd1, 8'h00, 8'h00, 8'h00},
        '{1'b0, 1'b1, 6'h10, 2'd3, 8'h11, 8'h22, 8'h33},
        '{1'b1, 1'b1, 6'h10, 2'd3, 8'h00, 8'h00, 8'h00},
        '{1'b0, 1'b0, 6'h20, 2'd3, 8'h44, 8'h55, 8'h66},
        '{1'b1, 1'b0, 6'h20, 2'd2, 8'h00, 8'h00, 8'h00},
        '{1'b0, 1'b1, 6'h38, 2'd3, 8'h77, 8'h88, 8'h99},
        '{1'b1, 1'b1, 6'h38, 2'd3, 8'h00, 8'h00, 8'h00},
        '{1'b0, 1'b0, 6'h3F, 2'd1, 8'h5A, 8'h00, 8'h00},
        '{1'b1, 1'b0, 6'h3A, 2'd1, 8'h00, 8'h00, 8'h00}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int we0, err0, exp_we, exp_err, mism;
        logic [5:0] a;
        logic [7:0] d;
        // R8: reset state
        repeat (3) @(negedge clk);
        chk("R8 reg_we in reset", reg_we, 0);
        chk("R8 miso_oe in reset", miso_oe, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 outputs after reset", {reg_we, addr_err, miso, miso_oe}, 0);

        // R1: drive enable follows chip select
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R1 miso_oe with cs low", miso_oe, 1);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1 miso_oe with cs high", {miso_oe, miso}, 0);

        // R2 R3 R4 R5 R6: table of frames
        for (int v = 0; v < 10; v++) begin
            tx_buf[0] = {VECS[v].rd, VECS[v].mb, VECS[v].addr};
            tx_buf[1] = VECS[v].d0;
            tx_buf[2] = VECS[v].d1;
            tx_buf[3] = VECS[v].d2;
            we0 = we_cnt;
            err0 = err_cnt;
            exp_we = 0;
            exp_err = 0;
            xfer(int'(VECS[v].nb) + 1, 8);
            a = VECS[v].addr;
            for (int k = 0; k < int'(VECS[v].nb); k++) begin
                if (VECS[v].rd) begin
                    d = (a <= 6'h39) ? exp_mem[a] : 8'h00;
                    chk($sformatf("R4 R6 read byte %0d of frame %0d", k, v), rx_buf[k + 1], d);
                end else if (a <= 6'h39) begin
                    exp_mem[a] = tx_buf[k + 1];
                    exp_we++;
                end
                if (a > 6'h39) exp_err++;
                if (VECS[v].mb) a = a + 1'b1;
            end
            chk($sformatf("R3 write strobes frame %0d", v), we_cnt - we0, exp_we);
            chk($sformatf("R6 error pulses frame %0d", v), err_cnt - err0, exp_err);
            mism = 0;
            for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) mism++;
            chk($sformatf("R2 R5 register file after frame %0d", v), mism, 0);
        end

        // R7: abort four bits into the second data byte
        tx_buf[0] = {1'b0, 1'b1, 6'h30};
        tx_buf[1] = 8'hC3;
        tx_buf[2] = 8'hFF;
        we0 = we_cnt;
        xfer(3, 4);
        exp_mem[6'h30] = 8'hC3;
        chk("R7 strobes on aborted frame", we_cnt - we0, 1);
        chk("R7 partial byte discarded", mem[6'h31], exp_mem[6'h31]);
        chk("R7 complete byte kept", mem[6'h30], 8'hC3);
        tx_buf[0] = {1'b1, 1'b0, 6'h30};
        xfer(2, 8);
        chk("R7 restart with command", rx_buf[1], 8'hC3);
        chk("R1 idle after frames", {miso_oe, reg_we, addr_err}, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule